// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block drives a successive-approximation converter from the digital side. A start pulse begins a sequence: the block produces the convert strobe and the select line in the order the chosen wiring needs, waits out the conversion interval, and then generates a serial clock and shifts the result in, most significant bit first. Each result leaves the block as one word on a valid/ready port. For a signed (fully differential) variant the result is sign-extended to the storage width.

Three wirings are supported. In the separate-convert wiring a dedicated convert line frames the whole sequence. In the shared wiring the select line also acts as convert. In the chain wiring several converters are daisy-chained behind one active-high select. All intervals are counted in system clock cycles. The counts are derived from the clock period and rounded up, so one netlist can be reused across clock rates by changing parameters.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset, and whenever reset is applied, `busy_o`, `word_valid_o`, `sclk_o` and `cnv_o` are low. `sel_o` is high while idle in mode codes 0, 1 and 3.
- R2: Mode code 0 (separate convert). `cnv_o` is high in every cycle from the first busy cycle through the last busy cycle. `sel_o` stays high for exactly the conversion interval and then stays low for the whole readout.
- R3: Mode code 1 (shared convert). `sel_o` is first held low for QUIET_NS rounded up to whole cycles (2 cycles at a 10 ns clock). It is then held high for the conversion interval and then low for the readout. `cnv_o` stays low throughout.
- R4: The conversion interval is the maximum conversion time divided by the clock period, rounded up. The times are 420 ns, or 320 ns with turbo, for 14-bit and 16-bit results. They are 500 ns, or 400 ns with turbo, for 18-bit results. At a 10 ns clock and 18 bits this gives 50 and 40 cycles.
- R5: Mode code 2 (chain). `sel_o` is low while idle. It goes high for the normal (non-turbo) conversion interval and stays high through the readout. CHAIN_DEVS words (at most 32) are delivered in the order they are shifted out, and `word_last_o` is set only on the final word. In the other modes one word is delivered, with `word_last_o` set.
- R6: `sclk_o` idles low outside the readout. `sel_o` never changes level in a cycle where `sclk_o` is high, or was high in the cycle before.
- R7: `cfg_err_o` is high when mode code 2 is combined with `turbo_i` high, and when mode code 3 is selected. While it is high, a start request is refused and `busy_o` stays low.
- R8: Each word takes RES_BITS serial clocks. Each clock is low for SCLK_DIV/2 cycles and then high for SCLK_DIV/2 cycles, so consecutive rising edges within a word are SCLK_DIV cycles apart. `sdi_i` is captured on each rising edge, most significant bit first.
- R9: Words are 32 bits wide when RES_BITS exceeds 16, and 16 bits wide otherwise. An 18-bit result is sign-extended from bit 17. Narrower results are zero-extended.
- R10: A start request that arrives while a sequence runs has no effect. The sequence keeps its timing, and no second sequence follows it.
- R11: `busy_o` is high from the cycle after an accepted start until the cycle after the final word handshake. While `word_valid_o` is high and `word_ready_i` is low, the word and its last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Wiring code: 0 separate convert, 1 shared convert, 2 chain, 3 reserved |
| turbo_i | input | 1 | Permanent turbo setting; selects the shorter conversion interval |
| start_i | input | 1 | Sample request, one cycle |
| busy_o | output | 1 | Sequence in progress |
| cfg_err_o | output | 1 | Illegal mode/turbo combination; start refused |
| cnv_o | output | 1 | Convert strobe (separate-convert wiring) |
| sel_o | output | 1 | Select line level (active low, or active high in chain) |
| sclk_o | output | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data from the converter |
| word_valid_o | output | 1 | Result word available |
| word_ready_i | input | 1 | Consumer accepts the word |
| word_data_o | output | STORE_W | Result, extended to storage width |
| word_last_o | output | 1 | Final word of the sequence |

## Verification
The bench counts, cycle by cycle, how long the select line sits low and high before the first serial clock edge. A design that used the turbo interval in chain mode, or skipped the quiet low time of the shared wiring, shows up as a wrong count. Results with bit 17 set check that sign extension happens; a design that zero-extends returns a positive word. Chain runs with a consumer that stalls between words catch a readout that drops or reorders words, a flag set on the wrong word, and data that moves while it waits. A second start during conversion and the refused chain-plus-turbo setting catch designs that restart the timer or begin a sequence when they should not.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    WIRE_SEP   = 2'd0,
    WIRE_SHARE = 2'd1,
    WIRE_CHAIN = 2'd2,
    WIRE_RSVD  = 2'd3
  } wiring_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_QUIET,
    S_CONV,
    S_SHIFT,
    S_DELIVER
  } seq_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Worst-case conversion time per variant, in nanoseconds.
  function automatic int conv_time_ns(input int res_bits, input bit turbo);
    if (res_bits > 16) return turbo ? 400 : 500;
    return turbo ? 320 : 420;
  endfunction

  function automatic int conv_cycles(input int res_bits, input bit turbo, input int period_ps);
    return ceil_div(conv_time_ns(res_bits, turbo) * 1000, period_ps);
  endfunction

  function automatic int store_width(input int res_bits);
    return (res_bits > 16) ? 32 : 16;
  endfunction

  function automatic bit signed_part(input int res_bits);
    return res_bits > 16;
  endfunction

endpackage

// File: rtl/sar_interval_timer.sv
module sar_interval_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R4: once loaded, the interval runs down one step per cycle
  assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sar_bit_shifter.sv
module sar_bit_shifter #(
  parameter int RES_BITS = 18,
  parameter int SCLK_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                sdi_i,
  output logic                sclk_o,
  output logic                word_done_o,
  output logic [RES_BITS-1:0] word_o
);

  localparam int HALF = SCLK_DIV / 2;
  localparam int PH_W = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int BC_W = $clog2(RES_BITS + 1);

  logic [PH_W-1:0]     ph_q;
  logic [BC_W-1:0]     bits_q;
  logic                sclk_q;
  logic [RES_BITS-1:0] sr_q;
  logic                rise_evt;
  logic                fall_evt;

  assign rise_evt    = run_i && (ph_q == PH_W'(HALF - 1));
  assign fall_evt    = run_i && (ph_q == PH_W'(SCLK_DIV - 1));
  assign word_done_o = fall_evt && (bits_q == BC_W'(RES_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bits_q <= '0;
      sclk_q <= 1'b0;
      sr_q   <= '0;
    end else if (!run_i) begin
      ph_q   <= '0;
      bits_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q <= fall_evt ? '0 : ph_q + 1'b1;
      if (rise_evt) begin
        sclk_q <= 1'b1;
        sr_q   <= {sr_q[RES_BITS-2:0], sdi_i};
        bits_q <= bits_q + 1'b1;
      end
      if (fall_evt) sclk_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;
  assign word_o = sr_q;

  // R6: clock parks low as soon as the readout stops
  assert_sclk_parks_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_o);

  // R8: never more captures than the result width
  assert_bit_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= BC_W'(RES_BITS));

endmodule

// File: rtl/sar_word_out.sv
module sar_word_out
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 18
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_i,
  input  logic                               last_i,
  input  logic [RES_BITS-1:0]                raw_i,
  input  logic                               ready_i,
  output logic                               valid_o,
  output logic [store_width(RES_BITS)-1:0]   data_o,
  output logic                               last_o
);

  localparam int  STORE_W = store_width(RES_BITS);
  localparam int  PAD     = STORE_W - RES_BITS;
  localparam bit  SIGNED  = signed_part(RES_BITS);

  logic [STORE_W-1:0] ext;

  generate
    if (PAD > 0) begin : g_pad
      assign ext = {{PAD{SIGNED ? raw_i[RES_BITS-1] : 1'b0}}, raw_i};
    end else begin : g_nopad
      assign ext = raw_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= ext;
      last_o  <= last_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R11: an offered word is held until taken
  assert_word_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS      = 18,
  parameter int CHAIN_DEVS    = 3,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SCLK_DIV      = 4,
  parameter int QUIET_NS      = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       mode_i,
  input  logic                             turbo_i,
  input  logic                             start_i,
  output logic                             busy_o,
  output logic                             cfg_err_o,
  output logic                             cnv_o,
  output logic                             sel_o,
  output logic                             sclk_o,
  input  logic                             sdi_i,
  output logic                             word_valid_o,
  input  logic                             word_ready_i,
  output logic [store_width(RES_BITS)-1:0] word_data_o,
  output logic                             word_last_o
);

  localparam int QUIET_RAW = ceil_div(QUIET_NS * 1000, CLK_PERIOD_PS);
  localparam int QUIET_CYC = (QUIET_RAW < 1) ? 1 : QUIET_RAW;
  localparam int NORM_CYC  = conv_cycles(RES_BITS, 1'b0, CLK_PERIOD_PS);
  localparam int TURBO_CYC = conv_cycles(RES_BITS, 1'b1, CLK_PERIOD_PS);
  localparam int MAX_CYC   = (NORM_CYC > QUIET_CYC) ? NORM_CYC : QUIET_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam int IDX_W     = (CHAIN_DEVS > 1) ? $clog2(CHAIN_DEVS) : 1;

  wiring_e          mode_in;
  wiring_e          mode_q;
  logic             turbo_q;
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_top;
  logic             is_last;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             shift_run;
  logic             word_done;
  logic             handshake;
  logic [RES_BITS-1:0] raw_word;

  function automatic logic [CNT_W-1:0] conv_len(input wiring_e m, input logic t);
    // chain wiring always waits the normal interval
    return (m == WIRE_CHAIN || !t) ? CNT_W'(NORM_CYC - 1) : CNT_W'(TURBO_CYC - 1);
  endfunction

  assign mode_in   = wiring_e'(mode_i);
  assign cfg_err_o = (mode_in == WIRE_RSVD) || (mode_in == WIRE_CHAIN && turbo_i);
  assign idx_top   = (mode_q == WIRE_CHAIN) ? IDX_W'(CHAIN_DEVS - 1) : '0;
  assign is_last   = (idx_q == idx_top);
  assign handshake = word_valid_o && word_ready_i;
  assign shift_run = (state_q == S_SHIFT);
  assign busy_o    = (state_q != S_IDLE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      S_IDLE: if (start_i && !cfg_err_o) begin
        tmr_load = 1'b1;
        if (mode_in == WIRE_SHARE) begin
          state_d = S_QUIET;
          tmr_val = CNT_W'(QUIET_CYC - 1);
        end else begin
          state_d = S_CONV;
          tmr_val = conv_len(mode_in, turbo_i);
        end
      end
      S_QUIET: if (tmr_expired) begin
        state_d  = S_CONV;
        tmr_load = 1'b1;
        tmr_val  = conv_len(mode_q, turbo_q);
      end
      S_CONV:    if (tmr_expired) state_d = S_SHIFT;
      S_SHIFT:   if (word_done)   state_d = S_DELIVER;
      S_DELIVER: if (handshake)   state_d = is_last ? S_IDLE : S_SHIFT;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= WIRE_SEP;
      turbo_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i && !cfg_err_o) begin
        mode_q  <= mode_in;
        turbo_q <= turbo_i;
        idx_q   <= '0;
      end else if (state_q == S_DELIVER && handshake && !is_last) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // Line levels per phase
  always_comb begin
    cnv_o = 1'b0;
    sel_o = 1'b1;
    case (state_q)
      S_IDLE:  sel_o = (mode_in != WIRE_CHAIN);
      S_QUIET: sel_o = 1'b0;
      S_CONV: begin
        sel_o = 1'b1;
        cnv_o = (mode_q == WIRE_SEP);
      end
      S_SHIFT, S_DELIVER: begin
        sel_o = (mode_q == WIRE_CHAIN);
        cnv_o = (mode_q == WIRE_SEP);
      end
      default: sel_o = 1'b1;
    endcase
  end

  sar_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  sar_bit_shifter #(.RES_BITS(RES_BITS), .SCLK_DIV(SCLK_DIV)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (shift_run),
    .sdi_i       (sdi_i),
    .sclk_o      (sclk_o),
    .word_done_o (word_done),
    .word_o      (raw_word)
  );

  sar_word_out #(.RES_BITS(RES_BITS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (word_done),
    .last_i  (is_last),
    .raw_i   (raw_word),
    .ready_i (word_ready_i),
    .valid_o (word_valid_o),
    .data_o  (word_data_o),
    .last_o  (word_last_o)
  );

  // R7: a refused start leaves the sequencer idle
  assert_cfg_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && cfg_err_o) |=> (state_q == S_IDLE));

  // R10: a start during conversion neither restarts nor retargets it
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CONV && start_i && !tmr_expired) |=> (state_q == S_CONV && $stable(mode_q)));

  // R3: shared wiring never touches the convert strobe
  assert_share_no_cnv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == WIRE_SHARE) |-> !cnv_o);

  // R6: select only moves while the serial clock rests low
  assert_sel_moves_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != $past(sel_o)) |-> (!sclk_o && !$past(sclk_o)));

  // R5: chain select stays asserted across the whole readout
  assert_chain_sel_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WIRE_CHAIN && (state_q == S_SHIFT || state_q == S_DELIVER)) |-> sel_o);

endmodule

// File: tb/sar_conv_sequencer_tb.sv
module sar_conv_sequencer_tb;

  localparam int RES    = 18;
  localparam int DEVS   = 3;
  localparam int DIV    = 4;
  localparam int PER_PS = 10000;
  localparam int HALF   = DIV / 2;
  localparam int FW     = RES * DEVS;
  localparam int NVEC   = 6;

  // fields: mode[60:59] turbo[58] stall[57:55] poke[54] d0[53:36] d1[35:18] d2[17:0]
  localparam logic [60:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 3'd0, 1'b0, 18'h2A5C3, 18'h00000, 18'h00000},
    {2'd0, 1'b1, 3'd2, 1'b1, 18'h0F0F1, 18'h00000, 18'h00000},
    {2'd1, 1'b0, 3'd0, 1'b0, 18'h3FFFF, 18'h00000, 18'h00000},
    {2'd1, 1'b1, 3'd1, 1'b1, 18'h00001, 18'h00000, 18'h00000},
    {2'd2, 1'b0, 3'd0, 1'b0, 18'h1ABCD, 18'h20000, 18'h15555},
    {2'd2, 1'b0, 3'd3, 1'b1, 18'h3FFFE, 18'h00000, 18'h1FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_in = 2'd0;
  logic        turbo_in = 1'b0;
  logic        start = 1'b0;
  logic        busy, cfg_err, cnv, sel, sclk, sdi;
  logic        valid, last;
  logic        word_ready = 1'b0;
  logic [31:0] data;

  always #5 clk = ~clk;

  sar_conv_sequencer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_in),
    .turbo_i      (turbo_in),
    .start_i      (start),
    .busy_o       (busy),
    .cfg_err_o    (cfg_err),
    .cnv_o        (cnv),
    .sel_o        (sel),
    .sclk_o       (sclk),
    .sdi_i        (sdi),
    .word_valid_o (valid),
    .word_ready_i (word_ready),
    .word_data_o  (data),
    .word_last_o  (last)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and per-run monitor
  logic [FW-1:0] frame_bits = '0;
  int  cur_mode = 0, stall_cfg = 0;
  int  ncyc = 0, fall_cnt = 0, rises = 0, last_rise = 0;
  int  n_pre_sel = 0, n_quiet = 0, cnv_bad = 0, selread_bad = 0, flip_bad = 0;
  int  period_bad = 0, stable_bad = 0, idle_bad = 0, busy_rises = 0, n_words = 0, stall_left = 0;
  logic [31:0] got_data [DEVS];
  logic        got_last [DEVS];
  logic [31:0] hold_data = '0;
  bit pend_idle = 0, prev_sel = 0, prev_sclk = 0, prev_busy = 0, prev_valid = 0;

  assign sdi = (fall_cnt < FW) ? frame_bits[FW-1-fall_cnt] : 1'b0;

  always @(negedge clk) begin
    ncyc++;
    if (busy && !prev_busy) begin
      fall_cnt = 0; rises = 0; n_pre_sel = 0; n_quiet = 0; cnv_bad = 0;
      selread_bad = 0; flip_bad = 0; period_bad = 0; stable_bad = 0;
      idle_bad = 0; n_words = 0; busy_rises++;
    end
    if (prev_sclk && !sclk) fall_cnt++;
    if (sclk && !prev_sclk) begin
      if ((rises % RES) != 0 && (ncyc - last_rise) != DIV) period_bad++;
      rises++;
      last_rise = ncyc;
    end
    if (busy && rises == 0) begin
      if (sel) n_pre_sel++;
      else if (n_pre_sel == 0) n_quiet++;
    end
    if (busy && rises > 0 && sel != (cur_mode == 2)) selread_bad++;
    if (cnv !== (busy && cur_mode == 0)) cnv_bad++;
    if (sel != prev_sel && (sclk || prev_sclk)) flip_bad++;
    if (pend_idle) begin
      if (busy) idle_bad++;
      pend_idle = 0;
    end
    if (valid) begin
      if (!prev_valid) hold_data = data;
      else if (data != hold_data) stable_bad++;
      if (!word_ready) begin
        if (stall_left > 0) stall_left--;
        else begin
          if (n_words < DEVS) begin
            got_data[n_words] = data;
            got_last[n_words] = last;
          end
          n_words++;
          word_ready = 1'b1;
          if (last) pend_idle = 1;
        end
      end else word_ready = 1'b0;
    end else begin
      word_ready = 1'b0;
      stall_left = stall_cfg;
    end
    prev_sel = sel; prev_sclk = sclk; prev_busy = busy; prev_valid = valid;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", wd, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_conv(input int m, input bit t);
    int ns;
    ns = (t && m != 2) ? 400 : 500;          // 18-bit variant, R4
    return (ns * 1000 + PER_PS - 1) / PER_PS;
  endfunction

  task automatic run_seq(input int m, input bit t, input int stall, input bit poke,
                         input logic [17:0] d0, input logic [17:0] d1, input logic [17:0] d2);
    int it, e_conv, e_pre, e_quiet, e_words;
    logic [17:0] dd [DEVS];
    string tag;
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    tag = (m == 0) ? "R2" : ((m == 1) ? "R3" : "R5");
    cur_mode = m; stall_cfg = stall; busy_rises = 0;
    frame_bits = (m == 2) ? {d0, d1, d2} : {d0, 36'b0};
    @(negedge clk); mode_in = 2'(m); turbo_in = t; start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    it = 0;
    while (busy) begin
      @(negedge clk);
      it++;
      start = (poke && it == 8);
      #1;
    end
    start = 1'b0;
    e_conv  = exp_conv(m, t);
    e_pre   = (m == 2) ? e_conv + HALF : e_conv;
    e_quiet = (m == 1) ? 2 : 0;
    e_words = (m == 2) ? DEVS : 1;
    check(n_pre_sel == e_pre, "R4 conversion cycles", n_pre_sel, e_pre);
    check(n_quiet == e_quiet, "R3 quiet low cycles", n_quiet, e_quiet);
    check(cnv_bad == 0, {tag, " convert strobe"}, cnv_bad, 0);
    check(selread_bad == 0, {tag, " select during readout"}, selread_bad, 0);
    check(flip_bad == 0, "R6 select moved with clock high", flip_bad, 0);
    check(rises == e_words * RES, "R8 serial clock count", rises, e_words * RES);
    check(period_bad == 0, "R8 serial clock period", period_bad, 0);
    check(n_words == e_words, "R5 word count", n_words, e_words);
    for (int i = 0; i < e_words; i++) begin
      check(got_data[i] == {{14{dd[i][17]}}, dd[i]}, "R9 result word",
            got_data[i], {{14{dd[i][17]}}, dd[i]});
      check(got_last[i] == (i == e_words - 1), "R5 last flag", got_last[i], (i == e_words - 1));
    end
    check(stable_bad == 0, "R11 word held while stalled", stable_bad, 0);
    check(idle_bad == 0, "R11 busy drops after final word", idle_bad, 0);
    if (poke) check(busy_rises == 1, "R10 start while busy ignored", busy_rises, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(busy == 0 && valid == 0, "R1 reset busy/valid", {busy, valid}, 0);
    check(sclk == 0 && cnv == 0, "R1 reset sclk/cnv", {sclk, cnv}, 0);
    check(sel == 1, "R1 idle select level", sel, 1);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      run_seq(int'(VEC[v][60:59]), VEC[v][58], int'(VEC[v][57:55]), VEC[v][54],
              VEC[v][53:36], VEC[v][35:18], VEC[v][17:0]);
    end

    // R7: chain with permanent turbo is refused
    @(negedge clk); mode_in = 2'd2; turbo_in = 1'b1; #1;
    check(cfg_err == 1, "R7 chain+turbo flagged", cfg_err, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(busy == 0 && sclk == 0, "R7 refused start stays idle", {busy, sclk}, 0);
    check(sel == 0, "R5 chain idle select low", sel, 0);
    @(negedge clk); mode_in = 2'd3; turbo_in = 1'b0; #1;
    check(cfg_err == 1, "R7 reserved code flagged", cfg_err, 1);
    @(negedge clk); mode_in = 2'd2; turbo_in = 1'b0; #1;
    check(cfg_err == 0, "R7 chain without turbo accepted", cfg_err, 0);

    // R1: reset in the middle of a sequence
    @(negedge clk); mode_in = 2'd0; cur_mode = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); #1;
    check(busy == 0 && cnv == 0 && valid == 0, "R1 reset aborts sequence",
          {busy, cnv, valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule